// File: doc/BRIEF.md
# Per-Frame Stream CRC Checker

This block checks a word stream made of a fixed number of frames. Each frame has a fixed number of data words, and one word carrying the expected checksum comes right after it. As data words are accepted on a valid/ready input, the block computes a 16-bit CRC over them. The CRC is computed afresh for every frame. When the checksum word arrives, the block compares it with the local result.

If every frame matches, the stream runs to its end and a sticky done flag rises. The first mismatch pulls an active-low status line low. From then on the block refuses all further input until it is reset. The contents of the frames are not interpreted and nothing is stored.

Top module: `frame_crc_checker`

## Requirements
- R1: While reset is applied and in the first cycle after it, `in_ready` is 1, `status_n` is 1 and `done` is 0.
- R2: The CRC is CRC-16 with polynomial 0x1021, seed 0xFFFF, no reflection and no final XOR. Each accepted 16-bit data word is folded in MSB first. The CRC register restarts from the seed at the first data word of every frame.
- R3: A beat is accepted only in a cycle where `in_valid` and `in_ready` are both 1. Each frame is FRAME_WORDS accepted data beats followed by one accepted checksum beat. Cycles with `in_valid` low change nothing.
- R4: A checksum beat equal to the frame's computed CRC leaves `status_n` at 1 and lets the next frame start.
- R5: A checksum beat that differs from the computed CRC drives `status_n` low from the next cycle. It stays low until reset.
- R6: After a mismatch, `in_ready` stays 0 until reset, and offered beats change none of the outputs.
- R7: In the cycle after the checksum beat of frame NUM_FRAMES-1 is accepted and matches, `done` goes to 1. It then stays 1 until reset, with `in_ready` at 0.
- R8: A reset in the middle of a frame discards all progress. The next beat is treated as word 0 of frame 0.
- R9: A mismatch on the final frame leaves `done` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream word offered |
| in_data | input | 16 | Stream word: data or checksum, depending on its position |
| in_ready | output | 1 | Block can accept a word |
| done | output | 1 | Every frame has been checked clean |
| status_n | output | 1 | Active-low error status |

## Verification
The assertions assume that `in_data` is meaningful only on cycles where a beat is accepted. They also assume that the stream source follows the frame layout, so the block can tell checksum beats from data beats only by counting. The bench therefore builds each stream from the exact frame geometry and computes the checksums with its own model. It corrupts the checksum word alone when it wants a mismatch, and it inserts idle cycles only by lowering `in_valid`. Beats offered after an error or after done are deliberately outside the layout. Those cases are checked purely at the ports.

// File: rtl/frame_crc_pkg.sv
package frame_crc_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_DONE = 2'd1,
      ST_FAIL = 2'd2
   } chk_state_e;

endpackage

// File: rtl/frame_crc_step.sv
module frame_crc_step #(
   parameter int DATA_W = 16,
   parameter int CRC_W  = 16,
   parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [CRC_W-1:0]  crc_out
);

   if (CRC_W < 2) begin : g_bad_crc_w
      $error("frame_crc_step: CRC_W must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("frame_crc_step: DATA_W must be at least 1");
   end

   logic [DATA_W:0][CRC_W-1:0] chain;
   assign chain[0] = crc_in;

   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      logic fb;
      assign fb = chain[g][CRC_W-1] ^ data_in[DATA_W-1-g];
      assign chain[g+1] = {chain[g][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign crc_out = chain[DATA_W];

endmodule

// File: rtl/frame_crc_seq.sv
module frame_crc_seq #(
   parameter int FRAME_WORDS = 4,
   parameter int NUM_FRAMES  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic advance,
   output logic first_word,
   output logic crc_beat,
   output logic last_frame
);

   localparam int WIDX_W = $clog2(FRAME_WORDS + 1);
   localparam int FIDX_W = $clog2(NUM_FRAMES + 1);
   localparam logic [WIDX_W-1:0] CRC_POS   = WIDX_W'(FRAME_WORDS);
   localparam logic [FIDX_W-1:0] LAST_FIDX = FIDX_W'(NUM_FRAMES - 1);

   if (FRAME_WORDS < 1) begin : g_bad_fw
      $error("frame_crc_seq: FRAME_WORDS must be at least 1");
   end
   if (NUM_FRAMES < 1) begin : g_bad_nf
      $error("frame_crc_seq: NUM_FRAMES must be at least 1");
   end

   logic [WIDX_W-1:0] word_idx;
   logic [FIDX_W-1:0] frame_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_idx  <= '0;
         frame_idx <= '0;
      end else if (advance) begin
         if (word_idx == CRC_POS) begin
            word_idx <= '0;
            if (frame_idx != LAST_FIDX) frame_idx <= frame_idx + 1'b1;
         end else begin
            word_idx <= word_idx + 1'b1;
         end
      end
   end

   assign first_word = (word_idx == '0);
   assign crc_beat   = (word_idx == CRC_POS);
   assign last_frame = (frame_idx == LAST_FIDX);

   // R3
   word_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_idx <= CRC_POS);
   // R3
   frame_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_idx <= LAST_FIDX);
   // R3
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(word_idx) && $stable(frame_idx));

endmodule

// File: rtl/frame_crc_checker.sv
module frame_crc_checker #(
   parameter int DATA_W      = 16,
   parameter int CRC_W       = 16,
   parameter logic [CRC_W-1:0] POLY = 16'h1021,
   parameter logic [CRC_W-1:0] SEED = 16'hFFFF,
   parameter int FRAME_WORDS = 4,
   parameter int NUM_FRAMES  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              done,
   output logic              status_n
);
   import frame_crc_pkg::*;

   if (DATA_W != CRC_W) begin : g_bad_width
      $error("frame_crc_checker: checksum beat must be as wide as the CRC");
   end

   chk_state_e        state;
   logic [CRC_W-1:0]  crc_q;
   logic [CRC_W-1:0]  crc_base;
   logic [CRC_W-1:0]  crc_next;
   logic              accept;
   logic              first_word;
   logic              crc_beat;
   logic              last_frame;

   assign in_ready = (state == ST_RUN);
   assign accept   = in_valid && in_ready;
   assign crc_base = first_word ? SEED : crc_q;

   frame_crc_seq #(
      .FRAME_WORDS(FRAME_WORDS),
      .NUM_FRAMES (NUM_FRAMES)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (accept),
      .first_word(first_word),
      .crc_beat  (crc_beat),
      .last_frame(last_frame)
   );

   frame_crc_step #(
      .DATA_W(DATA_W),
      .CRC_W (CRC_W),
      .POLY  (POLY)
   ) u_step (
      .crc_in (crc_base),
      .data_in(in_data),
      .crc_out(crc_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= SEED;
         state <= ST_RUN;
      end else if (accept) begin
         if (!crc_beat) begin
            crc_q <= crc_next;
         end else if (in_data != crc_q) begin
            state <= ST_FAIL;
         end else if (last_frame) begin
            state <= ST_DONE;
         end
      end
   end

   assign done     = (state == ST_DONE);
   assign status_n = (state != ST_FAIL);

   // R5
   status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !status_n |=> !status_n);
   // R5
   fail_needs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_n) |-> $past(accept && crc_beat));
   // R7
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);
   // R7
   done_needs_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(accept && crc_beat && last_frame));
   // R9
   done_excl_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && !status_n));
   // R6
   no_accept_after_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !status_n |-> !in_ready);

endmodule

// File: tb/frame_crc_checker_tb.sv
module frame_crc_checker_tb;

   localparam int CLK_PERIOD = 10;
   localparam int FW = 4;
   localparam int NF = 3;
   localparam int NVEC = 6;
   localparam int WATCHDOG = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic        in_ready, done, status_n;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   // vector fields: [12:9] corrupted frame (F = none), [8] idle gaps, [7:0] data tag
   localparam logic [12:0] VEC [NVEC] = '{
      {4'hF, 1'b0, 8'h11},
      {4'hF, 1'b1, 8'h22},
      {4'h0, 1'b0, 8'h33},
      {4'h1, 1'b1, 8'h44},
      {4'h2, 1'b0, 8'h55},
      {4'hF, 1'b0, 8'h00}
   };

   frame_crc_checker #(.FRAME_WORDS(FW), .NUM_FRAMES(NF)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .done(done), .status_n(status_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == WATCHDOG) begin
         failures = failures + 1;
         $display("FAIL watchdog expired act=%0d exp<%0d", cycles, WATCHDOG);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   function automatic logic [15:0] model_crc(input logic [15:0] c, input logic [15:0] w);
      int r = int'(c);
      for (int i = 15; i >= 0; i--) begin
         if ((((r >> 15) ^ (int'(w) >> i)) & 1) == 1) r = ((r << 1) ^ 'h1021) & 'hFFFF;
         else r = (r << 1) & 'hFFFF;
      end
      return r[15:0];
   endfunction

   function automatic logic [15:0] word_of(input logic [7:0] tag, input int f, input int w);
      return {tag, 8'h00} ^ 16'(f * 16'h0123) ^ 16'(w * 16'h1357) ^ {8'h00, tag};
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         failures = failures + 1;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic beat(input logic [15:0] d, input bit gap);
      in_valid = 1'b1;
      in_data = d;
      @(negedge clk);
      in_valid = 1'b0;
      if (gap) @(negedge clk);
   endtask

   // sends a full stream; returns early after the corrupted frame
   task automatic run_stream(input int bad, input bit gap, input logic [7:0] tag);
      logic [15:0] c;
      do_reset();
      for (int f = 0; f < NF; f++) begin
         c = 16'hFFFF;
         for (int w = 0; w < FW; w++) begin
            beat(word_of(tag, f, w), gap);
            c = model_crc(c, word_of(tag, f, w));
         end
         beat(c ^ ((f == bad) ? 16'h0001 : 16'h0000), gap);
         if (f == bad) begin
            check(status_n == 1'b0, "R5 status low after mismatch", status_n, 0);
            check(in_ready == 1'b0, "R6 ready low after mismatch", in_ready, 0);
            check(done == 1'b0, "R9 no done after mismatch", done, 0);
            return;
         end
         check(status_n == 1'b1, "R4 status high after good frame", status_n, 1);
         if (f < NF - 1)
            check(done == 1'b0 && in_ready == 1'b1, "R2 next frame open",
                  {done, in_ready}, 2'b01);
      end
      check(done == 1'b1, "R7 done after last frame", done, 1);
      check(in_ready == 1'b0, "R7 ready low when done", in_ready, 0);
   endtask

   initial begin
      // R1 reset state
      rst_n = 1'b0;
      #(CLK_PERIOD * 2 + 1);
      check(in_ready == 1'b1 && status_n == 1'b1 && done == 1'b0, "R1 during reset",
            {in_ready, status_n, done}, 3'b110);
      do_reset();
      check(in_ready == 1'b1 && status_n == 1'b1 && done == 1'b0, "R1 after reset",
            {in_ready, status_n, done}, 3'b110);

      // table walk: R2 R3 R4 R5 R9
      for (int v = 0; v < NVEC; v++) begin
         run_stream((VEC[v][12:9] == 4'hF) ? -1 : int'(VEC[v][12:9]), VEC[v][8], VEC[v][7:0]);
      end

      // R6: beats offered after a mismatch are ignored
      run_stream(1, 1'b0, 8'h66);
      for (int k = 0; k < 12; k++) beat(word_of(8'h66, 2, k % FW), 1'b0);
      check(status_n == 1'b0 && in_ready == 1'b0 && done == 1'b0, "R6 ignored after error",
            {status_n, in_ready, done}, 3'b000);

      // R7: done stays set while beats are offered
      run_stream(-1, 1'b0, 8'h77);
      for (int k = 0; k < 8; k++) beat(16'hFFFF, 1'b0);
      check(done == 1'b1 && status_n == 1'b1, "R7 done sticky", {done, status_n}, 2'b11);

      // R3: long idle stretch mid-frame does not disturb the count
      begin
         logic [15:0] c = 16'hFFFF;
         do_reset();
         for (int w = 0; w < FW; w++) begin
            beat(word_of(8'h88, 0, w), 1'b0);
            c = model_crc(c, word_of(8'h88, 0, w));
            if (w == 1) repeat (7) @(negedge clk);
         end
         beat(c, 1'b0);
         check(status_n == 1'b1 && in_ready == 1'b1, "R3 idle cycles ignored",
               {status_n, in_ready}, 2'b11);
      end

      // R8: reset mid-frame, then a clean stream must finish
      do_reset();
      beat(16'hDEAD, 1'b0);
      beat(16'hBEEF, 1'b0);
      run_stream(-1, 1'b0, 8'h99);
      check(done == 1'b1 && status_n == 1'b1, "R8 restart after mid-frame reset",
            {done, status_n}, 2'b11);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule